// File: doc/BRIEF.md
# Power-Management Control and Status Register

This block is the 32-bit power-management control/status word of a configuration-space function. It keeps the function's device power state, which is either fully on (D0) or the hot low-power state (D3hot). It also keeps a wake-event (PME) enable bit and a sticky PME status bit. Software reads and writes the word through a dword-addressed configuration port with per-byte enables. Reads always return the live register view, including in D3hot. The PME bits live in an always-on domain. Only the power-on reset clears them; the function reset does not.

A small state machine holds the power state. Its states are `ST_D0` (running), `ST_D3HOT` (low power) and `ST_RESUME` (a one-cycle exit state). The transitions are:
- `ST_D0` to `ST_D3HOT` on a D3hot write.
- `ST_D3HOT` to `ST_RESUME` on a D0 write.
- `ST_RESUME` to `ST_D0` or `ST_D3HOT`, depending on any write in that cycle.

While the machine is in `ST_D3HOT`, memory/IO decode and interrupts are blocked. `ST_RESUME` drives a single-cycle soft-reset pulse to the rest of the function. Power-state codes 01 and 10 are accepted on the bus but then discarded.

Top module: `pm_csr_reg`

## Requirements
- R1: After power-on reset the register reads 00000000h, and `pme_req`, `mem_io_block`, `irq_block` and `soft_rst` are all low.
- R2: A read at dword address 15h (byte offset 54h) returns the power state in bits 1:0, PME enable in bit 8 and PME status in bit 15. Reads at any other address return 0. Writes to any other address change nothing.
- R3: All other bits (31:16, 14:9, 7:2) read as zero whatever is written to them.
- R4: Writing 11 to bits 1:0 selects D3hot. From the cycle after the write, bits 1:0 read 11 and `mem_io_block` and `irq_block` are high.
- R5: A write of 01 or 10 to bits 1:0 is discarded, and the power state does not change.
- R6: Writing 00 while in D3hot returns the state to D0. `soft_rst` is high for exactly the one cycle after the write. In that cycle bits 1:0 read 00 and both block outputs are low.
- R7: Writing the current state again (00 in D0, or 11 in D3hot) gives no `soft_rst` pulse and no change on the block outputs.
- R8: `pme_event` sets PME status on the next edge. Writing 1 to bit 15 clears it, and writing 0 to bit 15 has no effect. If an event and a clearing write arrive in the same cycle, the bit stays set.
- R9: PME enable is a plain read/write bit. `pme_req` is high exactly when PME enable and PME status are both 1.
- R10: Byte enable 0 gates the power-state write. Byte enable 1 gates both the PME enable write and the PME status clear. A lane that is not enabled leaves its bits unchanged.
- R11: `func_rst_n` low returns the power state to D0 without a `soft_rst` pulse and leaves both PME bits unchanged. Only `por_n` clears the PME bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| func_rst_n | input | 1 | Function reset, active low, clears the power state only |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword address |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data for `cfg_dw_addr` |
| pme_event | input | 1 | Wake event from the function |
| pme_req | output | 1 | Wake request level |
| mem_io_block | output | 1 | Blocks memory and IO decode in D3hot |
| irq_block | output | 1 | Masks interrupts in D3hot |
| soft_rst | output | 1 | One-cycle internal warm-reset pulse |

## Verification
The bench goes after three groups of corner cases.

The first group is D3hot exit timing. A design that pulses on the same edge as the write, or that holds the pulse for two cycles, fails the soft-reset checks. So does one that pulses on a repeated D0 write.

The second group is the reserved codes 01 and 10. A design that stores these codes shows them on bits 1:0 or drops the gating.

The third group is the PME status bit. The bench checks its priority against a same-cycle clear and its byte-lane gating. A design that lets the clear win, or that ignores `cfg_be[1]`, loses a wake event or clears one it should keep.

Finally, the bench asserts the function reset while PME bits are set. A design that wired those bits to the function reset reads them back as 0.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D3HOT = 2'b11
    } pwr_code_e;

    typedef enum logic [1:0] {
        ST_D0     = 2'd0,
        ST_D3HOT  = 2'd1,
        ST_RESUME = 2'd2
    } pm_state_e;

    localparam int unsigned PS_LSB     = 0;
    localparam int unsigned PME_EN_BIT = 8;
    localparam int unsigned PME_ST_BIT = 15;

endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pm_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps_wr,
    input  logic [1:0] ps_wdata,
    output logic [1:0] ps_view,
    output logic       in_low_power,
    output logic       soft_rst
);

    pm_state_e state_q, state_d;

    // next state: reserved codes fall through and keep the state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_D0: begin
                if (ps_wr && ps_wdata == PS_D3HOT) state_d = ST_D3HOT;
            end
            ST_D3HOT: begin
                if (ps_wr && ps_wdata == PS_D0) state_d = ST_RESUME;
            end
            ST_RESUME: begin
                if (ps_wr && ps_wdata == PS_D3HOT) state_d = ST_D3HOT;
                else                               state_d = ST_D0;
            end
            default: state_d = ST_D0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_D0;
        else        state_q <= state_d;
    end

    always_comb begin
        ps_view      = PS_D0;
        in_low_power = 1'b0;
        soft_rst     = 1'b0;
        unique case (state_q)
            ST_D0:     ps_view = PS_D0;
            ST_D3HOT: begin
                ps_view      = PS_D3HOT;
                in_low_power = 1'b1;
            end
            ST_RESUME: soft_rst = 1'b1;
            default:   ps_view = PS_D0;
        endcase
    end

    p_d3_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr && ps_wdata == PS_D3HOT) |=> in_low_power);

    p_rsvd_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr && (ps_wdata == 2'b01 || ps_wdata == 2'b10) && state_q != ST_RESUME)
        |=> $stable(ps_view));

    p_wake_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr && ps_wdata == PS_D0 && in_low_power) |=> (soft_rst && !in_low_power));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_same_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr && ps_wdata == PS_D0 && !in_low_power) |=> !soft_rst);

endmodule

// File: rtl/pme_resume_bits.sv
module pme_resume_bits (
    input  logic clk,
    input  logic por_n,
    input  logic lane_wr,
    input  logic en_wdata,
    input  logic clr_wdata,
    input  logic pme_event,
    output logic pme_en,
    output logic pme_sts,
    output logic pme_req
);

    logic clr_hit;
    assign clr_hit = lane_wr && clr_wdata;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pme_en  <= 1'b0;
            pme_sts <= 1'b0;
        end else begin
            if (lane_wr) pme_en <= en_wdata;
            // event beats a same-cycle write-one-to-clear
            if (pme_event)    pme_sts <= 1'b1;
            else if (clr_hit) pme_sts <= 1'b0;
        end
    end

    assign pme_req = pme_en & pme_sts;

    p_event_sets_r8: assert property (@(posedge clk) disable iff (!por_n)
        pme_event |=> pme_sts);

    p_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
        (clr_hit && !pme_event) |=> !pme_sts);

    p_sts_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
        (!pme_event && !clr_hit) |=> $stable(pme_sts));

    p_en_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        !lane_wr |=> $stable(pme_en));

endmodule

// File: rtl/pm_csr_reg.sv
module pm_csr_reg
    import pm_csr_pkg::*;
#(
    parameter logic [5:0] REG_DWORD = 6'h15
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        func_rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [31:0] cfg_wdata,
    input  logic [3:0]  cfg_be,
    output logic [31:0] cfg_rdata,
    input  logic        pme_event,
    output logic        pme_req,
    output logic        mem_io_block,
    output logic        irq_block,
    output logic        soft_rst
);

    localparam logic [31:0] LIVE_MASK = (32'h3 << PS_LSB) | (32'h1 << PME_EN_BIT)
                                      | (32'h1 << PME_ST_BIT);
    localparam logic [31:0] ZERO_MASK = ~LIVE_MASK;

    logic        fn_rst_n;
    logic        hit, ps_wr, pm_lane_wr;
    logic [1:0]  ps_view;
    logic        low_power;
    logic        pme_en, pme_sts;
    logic [31:0] reg_view;

    assign fn_rst_n   = por_n & func_rst_n;
    assign hit        = cfg_wr && (cfg_dw_addr == REG_DWORD);
    assign ps_wr      = hit && cfg_be[0];
    assign pm_lane_wr = hit && cfg_be[1];

    pm_state_fsm u_fsm (
        .clk          (clk),
        .rst_n        (fn_rst_n),
        .ps_wr        (ps_wr),
        .ps_wdata     (cfg_wdata[PS_LSB +: 2]),
        .ps_view      (ps_view),
        .in_low_power (low_power),
        .soft_rst     (soft_rst)
    );

    pme_resume_bits u_pme (
        .clk       (clk),
        .por_n     (por_n),
        .lane_wr   (pm_lane_wr),
        .en_wdata  (cfg_wdata[PME_EN_BIT]),
        .clr_wdata (cfg_wdata[PME_ST_BIT]),
        .pme_event (pme_event),
        .pme_en    (pme_en),
        .pme_sts   (pme_sts),
        .pme_req   (pme_req)
    );

    always_comb begin
        reg_view                 = '0;
        reg_view[PS_LSB +: 2]    = ps_view;
        reg_view[PME_EN_BIT]     = pme_en;
        reg_view[PME_ST_BIT]     = pme_sts;
    end

    assign cfg_rdata    = (cfg_dw_addr == REG_DWORD) ? reg_view : '0;
    assign mem_io_block = low_power;
    assign irq_block    = low_power;

    p_zero_bits_r3: assert property (@(posedge clk) disable iff (!por_n)
        (hit && ((|cfg_be[3:2]) || (|(cfg_wdata & ZERO_MASK))))
        |=> ((reg_view & ZERO_MASK) == '0));

    p_gates_agree_r4: assert property (@(posedge clk) disable iff (!fn_rst_n)
        (mem_io_block == irq_block) && !(soft_rst && mem_io_block));

    p_miss_no_write_r2: assert property (@(posedge clk) disable iff (!fn_rst_n)
        (cfg_wr && cfg_dw_addr != REG_DWORD && !pme_event) |=> $stable(reg_view));

endmodule

// File: tb/sim_pm_csr_reg.sv
module sim_pm_csr_reg;

    logic        clk = 1'b0;
    logic        por_n, func_rst_n, cfg_wr, pme_event;
    logic [5:0]  cfg_dw_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [3:0]  cfg_be;
    logic        pme_req, mem_io_block, irq_block, soft_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected model
    logic [1:0] m_ps;
    logic       m_en, m_sts, m_pulse;

    always #2.5 clk = ~clk;

    pm_csr_reg u0 (
        .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n), .cfg_wr(cfg_wr),
        .cfg_dw_addr(cfg_dw_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
        .cfg_rdata(cfg_rdata), .pme_event(pme_event), .pme_req(pme_req),
        .mem_io_block(mem_io_block), .irq_block(irq_block), .soft_rst(soft_rst)
    );

    function automatic logic [31:0] exp_view(logic [1:0] ps, logic en, logic sts);
        logic [31:0] v = '0;
        v[1:0] = ps;
        v[8]   = en;
        v[15]  = sts;
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        cfg_wr = 1'b0; cfg_dw_addr = 6'h15; cfg_wdata = '0; cfg_be = '0; pme_event = 1'b0;
    endtask

    task automatic check_all(string tag);
        chk({tag, " R2 rdata"}, cfg_rdata, exp_view(m_ps, m_en, m_sts));
        chk({tag, " R9 pme_req"}, 32'(pme_req), 32'(m_en & m_sts));
        chk({tag, " R4 mem_io_block"}, 32'(mem_io_block), 32'(m_ps == 2'b11));
        chk({tag, " R4 irq_block"}, 32'(irq_block), 32'(m_ps == 2'b11));
        chk({tag, " R6 soft_rst"}, 32'(soft_rst), 32'(m_pulse));
    endtask

    // one clock: drive, update model, sample after the edge
    task automatic step(string tag, logic wr, logic [5:0] a, logic [31:0] d,
                        logic [3:0] be, logic ev);
        cfg_wr = wr; cfg_dw_addr = a; cfg_wdata = d; cfg_be = be; pme_event = ev;
        m_pulse = 1'b0;
        if (wr && a == 6'h15) begin
            if (be[0]) begin
                if (d[1:0] == 2'b11) m_ps = 2'b11;
                else if (d[1:0] == 2'b00) begin
                    if (m_ps == 2'b11) m_pulse = 1'b1;
                    m_ps = 2'b00;
                end
            end
            if (be[1]) begin
                m_en = d[8];
                if (d[15]) m_sts = 1'b0;
            end
        end
        if (ev) m_sts = 1'b1;
        @(posedge clk);
        #1;
        idle_bus();
        #1;
        check_all(tag);
    endtask

    initial begin
        #150000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd4242);
        idle_bus();
        por_n = 1'b0; func_rst_n = 1'b0;
        m_ps = 2'b00; m_en = 1'b0; m_sts = 1'b0; m_pulse = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        por_n = 1'b1; func_rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1 after release");

        // R3: write all ones at byte lanes 3..2 and reserved bits
        step("R3 reserved bits", 1'b1, 6'h15, 32'hFFFF_7EFC, 4'b1100, 1'b0);
        chk("R3 zero upper", cfg_rdata, 32'h0);
        // R2: other address ignored and reads zero
        step("R2 miss write", 1'b1, 6'h16, 32'h0000_8103, 4'hF, 1'b0);
        cfg_dw_addr = 6'h16; #1;
        chk("R2 miss read", cfg_rdata, 32'h0);
        cfg_dw_addr = 6'h15; #1;
        // R5: reserved codes
        step("R5 code 01", 1'b1, 6'h15, 32'h1, 4'h1, 1'b0);
        step("R5 code 10", 1'b1, 6'h15, 32'h2, 4'h1, 1'b0);
        // R7: D0 again in D0
        step("R7 d0 in d0", 1'b1, 6'h15, 32'h0, 4'h1, 1'b0);
        // R4: enter D3hot
        step("R4 enter d3", 1'b1, 6'h15, 32'h3, 4'h1, 1'b0);
        step("R7 d3 in d3", 1'b1, 6'h15, 32'h3, 4'h1, 1'b0);
        step("R5 code 10 in d3", 1'b1, 6'h15, 32'h2, 4'h1, 1'b0);
        // R10: lane 0 disabled, no exit
        step("R10 be0 off", 1'b1, 6'h15, 32'h0, 4'hE, 1'b0);
        // R6: exit with pulse, then pulse drops
        step("R6 exit d3", 1'b1, 6'h15, 32'h0, 4'h1, 1'b0);
        step("R6 pulse ends", 1'b0, 6'h15, 32'h0, 4'h0, 1'b0);
        // R8: event, W0 no effect, W1C, event wins
        step("R8 event", 1'b0, 6'h15, 32'h0, 4'h0, 1'b1);
        step("R9 enable", 1'b1, 6'h15, 32'h0000_0100, 4'h2, 1'b0);
        step("R8 write zero", 1'b1, 6'h15, 32'h0000_0100, 4'h2, 1'b0);
        step("R10 be1 off clear", 1'b1, 6'h15, 32'h0000_8000, 4'h1, 1'b0);
        step("R8 event wins", 1'b1, 6'h15, 32'h0000_8100, 4'h2, 1'b1);
        step("R8 w1c", 1'b1, 6'h15, 32'h0000_8100, 4'h2, 1'b0);
        step("R8 event again", 1'b0, 6'h15, 32'h0, 4'h0, 1'b1);
        step("R4 enter d3 again", 1'b1, 6'h15, 32'h3, 4'h1, 1'b0);

        // R11: function reset keeps PME bits, no pulse
        func_rst_n = 1'b0; m_ps = 2'b00; m_pulse = 1'b0;
        #2;
        check_all("R11 func reset");
        @(posedge clk); #1; func_rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R11 after func reset");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] d = $urandom;
            logic [5:0]  a = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h15;
            d[1:0] = ($urandom_range(0, 1) == 1) ? 2'($urandom) : d[1:0];
            step("R10 random", 1'($urandom_range(0, 1)), a, d,
                 4'($urandom), ($urandom_range(0, 3) == 0));
        end

        // R11: power-on reset clears PME bits
        step("R11 prep", 1'b1, 6'h15, 32'h0000_0103, 4'h3, 1'b1);
        por_n = 1'b0; m_ps = 2'b00; m_en = 1'b0; m_sts = 1'b0; m_pulse = 1'b0;
        #2;
        check_all("R11 por clears");
        @(posedge clk); #1; por_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1 after por");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule